// File: doc/BRIEF.md
# Float to Signed Integer Converter

This block turns an unpacked floating-point operand into a signed two's-complement integer. The fractional part is always truncated toward zero. The operand arrives as separate fields:

- a two-bit class code,
- a sign bit,
- a signed unbiased exponent,
- a mantissa whose most significant bit is the explicit leading one.

The mantissa's most significant bit carries weight 2^exponent.

The result is registered and leaves the block one cycle after the operand, together with two flags:

- an invalid-conversion flag, raised when the value cannot be represented;
- an inexact flag, raised when non-zero fraction bits were discarded.

An unrepresentable value saturates asymmetrically. It gives the largest positive integer plus the sign bit, so positive values go to the top of the range and negative values go to the bottom. The integer width is a parameter: 32 bits by default, and 64 for the wide variant.

Top module: `f2i_convert`

## Requirements
- R1: While `rst_n` is low at a rising edge, the next state has `out_valid`, `out_int`, `out_invalid` and `out_inexact` all at zero.
- R2: An operand presented with `in_valid` high at a rising edge gives its result and `out_valid` high after that edge, with exactly one register stage.
- R3: When `in_valid` is low at an edge, `out_valid` goes low and `out_int`, `out_invalid` and `out_inexact` keep their previous values, whatever the other inputs carry.
- R4: Class code 2'b00 (zero) gives `out_int` = 0 with both flags clear, regardless of sign, exponent and mantissa.
- R5: Class code 2'b01 (number) with exponent e in [0, INT_W-1] gives a magnitude of floor(mant * 2^(e-(MANT_W-1))). No rounding increment is ever added.
- R6: A number with a negative exponent has magnitude 0. Its inexact flag is set, because the mantissa is non-zero.
- R7: For a representable number, `out_inexact` is 1 exactly when some non-zero mantissa bit lies below the integer point.
- R8: A representable negative number outputs the two's-complement negation of its magnitude. A magnitude of exactly 2^(INT_W-1) with sign 1 is representable.
- R9: A number whose exponent is at least INT_W, or whose magnitude is at least 2^(INT_W-1)+sign, overflows. It outputs 2^(INT_W-1)-1+sign, sets `out_invalid` and clears `out_inexact`.
- R10: Class codes 2'b10 (infinity) and 2'b11 (NaN) produce the same saturated value and flags as an overflow of the same sign.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operand strobe |
| in_class | input | 2 | 00 zero, 01 number, 10 infinity, 11 NaN |
| in_sign | input | 1 | Operand sign, 1 = negative |
| in_exp | input | EXP_W | Signed unbiased exponent |
| in_mant | input | MANT_W | Mantissa, MSB is the explicit leading one |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_int | output | INT_W | Truncated two's-complement result |
| out_invalid | output | 1 | Conversion out of range, infinity or NaN |
| out_inexact | output | 1 | Non-zero fraction bits were dropped |

## Verification
Several properties are checked every cycle:

- reset clearing;
- the one-cycle valid timing and the hold when idle;
- zero-class results;
- saturation for infinity, NaN and oversized exponents;
- mutual exclusion of the two flags;
- the sign of negative results.

The exact truncated magnitudes, the discarded-bit detection and the boundary at -2^(INT_W-1) versus +2^(INT_W-1) need computed reference values. These are shown only by the bench's sweep of every normalized mantissa over an exponent range that spans both sides of the integer window, at a reduced 8-bit integer width.

// File: rtl/f2i_pkg.sv
// Shared definitions for the float-to-integer converter.
// Assumes the class code is two bits wide and stable for all users.
package f2i_pkg;

    typedef enum logic [1:0] {
        CLS_ZERO = 2'b00,
        CLS_NUM  = 2'b01,
        CLS_INF  = 2'b10,
        CLS_NAN  = 2'b11
    } f2i_class_e;

endpackage

// File: rtl/f2i_align.sv
// Aligns a normalized mantissa to the integer point.
// Produces the integer magnitude, a flag for dropped non-zero bits,
// and a flag for exponents too large for the integer width.
// Assumes EXP_W can hold INT_W as a positive signed value.
module f2i_align #(
    parameter int INT_W  = 32,
    parameter int MANT_W = 24,
    parameter int EXP_W  = 12
) (
    input  logic [EXP_W-1:0]  exp_i,
    input  logic [MANT_W-1:0] mant_i,
    output logic [INT_W-1:0]  mag_o,
    output logic              lost_o,
    output logic              exp_big_o
);
    localparam int EXT_W = INT_W + MANT_W;
    localparam int SH_W  = $clog2(INT_W + 1);
    localparam logic signed [EXP_W:0] EXP_LIM = (EXP_W+1)'(INT_W);
    localparam logic signed [EXP_W:0] EXP_ONE = (EXP_W+1)'(1);
    localparam logic signed [EXP_W:0] EXP_M1  = -(EXP_W+1)'(1);

    logic signed [EXP_W:0] exp_s;
    logic signed [EXP_W:0] sh_full;
    logic [SH_W-1:0]       sh;
    logic [EXT_W-1:0]      ext;
    logic                  exp_far_neg;

    // Sign-extend the exponent and derive the left-shift distance.
    always_comb begin
        exp_s       = {exp_i[EXP_W-1], exp_i};
        sh_full     = exp_s + EXP_ONE;
        sh          = sh_full[SH_W-1:0];
        exp_big_o   = (exp_s >= EXP_LIM);
        exp_far_neg = (exp_s < EXP_M1);
    end

    // Shift the mantissa so that bit MANT_W of ext has weight one.
    always_comb begin
        ext = EXT_W'(mant_i) << sh;
    end

    // Split the shifted vector into magnitude and lost fraction.
    always_comb begin
        if (exp_big_o) begin
            mag_o  = '0;
            lost_o = 1'b0;
        end else if (exp_far_neg) begin
            mag_o  = '0;
            lost_o = |mant_i;
        end else begin
            mag_o  = ext[EXT_W-1:MANT_W];
            lost_o = |ext[MANT_W-1:0];
        end
    end

endmodule

// File: rtl/f2i_range.sv
// Range check, saturation and sign application.
// Decides between the signed truncated value and the saturated code
// 2^(INT_W-1)-1+sign, and sets the invalid and inexact flags.
module f2i_range
    import f2i_pkg::*;
#(
    parameter int INT_W = 32
) (
    input  logic [1:0]       class_i,
    input  logic             sign_i,
    input  logic [INT_W-1:0] mag_i,
    input  logic             lost_i,
    input  logic             exp_big_i,
    output logic [INT_W-1:0] res_o,
    output logic             invalid_o,
    output logic             inexact_o
);
    logic             mag_ovf;
    logic [INT_W-1:0] sat;
    logic [INT_W-1:0] signed_mag;

    // Magnitude limit: at least 2^(INT_W-1) + sign overflows.
    always_comb begin
        mag_ovf = mag_i[INT_W-1] && (!sign_i || (|mag_i[INT_W-2:0]));
    end

    // Saturated code and two's-complement application of the sign.
    always_comb begin
        sat        = {sign_i, {(INT_W-1){~sign_i}}};
        signed_mag = sign_i ? (INT_W'(0) - mag_i) : mag_i;
    end

    // Select the result and flags by operand class.
    always_comb begin
        unique case (f2i_class_e'(class_i))
            CLS_ZERO: begin
                res_o     = '0;
                invalid_o = 1'b0;
                inexact_o = 1'b0;
            end
            CLS_NUM: begin
                if (exp_big_i || mag_ovf) begin
                    res_o     = sat;
                    invalid_o = 1'b1;
                    inexact_o = 1'b0;
                end else begin
                    res_o     = signed_mag;
                    invalid_o = 1'b0;
                    inexact_o = lost_i;
                end
            end
            default: begin
                res_o     = sat;
                invalid_o = 1'b1;
                inexact_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/f2i_convert.sv
// Top level of the truncating float-to-signed-integer converter.
// Combinational alignment and range logic are followed by one output
// register stage. Data registers load only on in_valid.
// Assumes a normalized mantissa for the number class.
module f2i_convert #(
    parameter int INT_W  = 32,
    parameter int MANT_W = 24,
    parameter int EXP_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [1:0]        in_class,
    input  logic              in_sign,
    input  logic [EXP_W-1:0]  in_exp,
    input  logic [MANT_W-1:0] in_mant,
    output logic              out_valid,
    output logic [INT_W-1:0]  out_int,
    output logic              out_invalid,
    output logic              out_inexact
);
    logic [INT_W-1:0] mag;
    logic             lost;
    logic             exp_big;
    logic [INT_W-1:0] res;
    logic             invalid;
    logic             inexact;

    f2i_align #(
        .INT_W (INT_W),
        .MANT_W(MANT_W),
        .EXP_W (EXP_W)
    ) u_align (
        .exp_i    (in_exp),
        .mant_i   (in_mant),
        .mag_o    (mag),
        .lost_o   (lost),
        .exp_big_o(exp_big)
    );

    f2i_range #(
        .INT_W(INT_W)
    ) u_range (
        .class_i  (in_class),
        .sign_i   (in_sign),
        .mag_i    (mag),
        .lost_i   (lost),
        .exp_big_i(exp_big),
        .res_o    (res),
        .invalid_o(invalid),
        .inexact_o(inexact)
    );

    // Valid strobe follows the input strobe by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= in_valid;
    end

    // Result and flags load on accepted operands, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_int     <= '0;
            out_invalid <= 1'b0;
            out_inexact <= 1'b0;
        end else if (in_valid) begin
            out_int     <= res;
            out_invalid <= invalid;
            out_inexact <= inexact;
        end
    end

endmodule

// File: rtl/f2i_convert_chk.sv
// Cycle-level properties of f2i_convert, attached with bind.
module f2i_convert_chk #(
    parameter int INT_W = 32,
    parameter int EXP_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [1:0]       in_class,
    input logic             in_sign,
    input logic [EXP_W-1:0] in_exp,
    input logic             out_valid,
    input logic [INT_W-1:0] out_int,
    input logic             out_invalid,
    input logic             out_inexact
);
    localparam logic [INT_W-1:0] SAT_POS = {1'b0, {(INT_W-1){1'b1}}};
    localparam logic [INT_W-1:0] SAT_NEG = {1'b1, {(INT_W-1){1'b0}}};
    localparam logic signed [EXP_W:0] EXP_LIM = (EXP_W+1)'(INT_W);

    logic signed [EXP_W:0] exp_s;
    assign exp_s = {in_exp[EXP_W-1], in_exp};

    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_int == '0 && !out_invalid && !out_inexact));

    p_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && $past(rst_n)) |=> (!out_valid && $stable(out_int)
            && $stable(out_invalid) && $stable(out_inexact)));

    p_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_class == 2'b00) |=> (out_int == '0 && !out_invalid && !out_inexact));

    p_negsign_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_class == 2'b01 && in_sign) |=>
            (out_invalid || out_int == '0 || out_int[INT_W-1]));

    p_bigexp_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_class == 2'b01 && exp_s >= EXP_LIM) |=>
            (out_invalid && out_int == ($past(in_sign) ? SAT_NEG : SAT_POS)));

    p_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_invalid |-> !out_inexact);

    p_special_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_class[1]) |=>
            (out_invalid && !out_inexact && out_int == ($past(in_sign) ? SAT_NEG : SAT_POS)));

endmodule

bind f2i_convert f2i_convert_chk #(
    .INT_W(INT_W),
    .EXP_W(EXP_W)
) u_f2i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_class   (in_class),
    .in_sign    (in_sign),
    .in_exp     (in_exp),
    .out_valid  (out_valid),
    .out_int    (out_int),
    .out_invalid(out_invalid),
    .out_inexact(out_inexact)
);

// File: tb/f2i_convert_bench.sv
`timescale 1ns/1ps
module f2i_convert_bench;
    localparam int TI = 8;
    localparam int TM = 6;
    localparam int TE = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [1:0]    in_class = 2'b00;
    logic          in_sign = 1'b0;
    logic [TE-1:0] in_exp = '0;
    logic [TM-1:0] in_mant = '0;
    logic          out_valid;
    logic [TI-1:0] out_int;
    logic          out_invalid;
    logic          out_inexact;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    f2i_convert #(.INT_W(TI), .MANT_W(TM), .EXP_W(TE)) u_f2i_convert (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_class(in_class),
        .in_sign(in_sign), .in_exp(in_exp), .in_mant(in_mant),
        .out_valid(out_valid), .out_int(out_int),
        .out_invalid(out_invalid), .out_inexact(out_inexact)
    );

    task automatic chk(input string tag, input longint act, input longint exp_v);
        checks++;
        if (act != exp_v) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp_v);
        end
    endtask

    // Reference model computed arithmetically from the requirements.
    task automatic run_vec(input int cls, input int sgn, input int e, input int m);
        longint mag, res;
        bit     lost, inv, inx;
        string  tag;
        lost = 1'b0;
        mag  = 0;
        if (cls == 0) begin
            res = 0; inv = 0; inx = 0; tag = "R4";
        end else if (cls >= 2) begin
            res = 127 + sgn; inv = 1; inx = 0; tag = "R10";
        end else begin
            if (e >= TI) begin
                inv = 1;
            end else begin
                if (e >= TM - 1) mag = longint'(m) << (e - (TM - 1));
                else begin
                    mag  = longint'(m) >> ((TM - 1) - e);
                    lost = (longint'(m) % (longint'(1) << ((TM - 1) - e))) != 0;
                end
                inv = (mag >= 128 + sgn);
            end
            if (inv) begin
                res = 127 + sgn; inx = 0; tag = "R9";
            end else begin
                res = sgn ? ((256 - mag) & 255) : mag;
                inx = lost;
                tag = (e < 0) ? "R6" : (sgn ? "R8" : "R5");
            end
        end
        @(negedge clk);
        in_valid = 1'b1;
        in_class = 2'(cls);
        in_sign  = sgn[0];
        in_exp   = e[TE-1:0];
        in_mant  = m[TM-1:0];
        @(negedge clk);
        in_valid = 1'b0;
        chk("R2 out_valid", longint'(out_valid), 1);
        chk(tag, longint'(out_int), res);
        chk({tag, " invalid"}, longint'(out_invalid), longint'(inv));
        chk("R7 inexact", longint'(out_inexact), longint'(inx));
    endtask

    initial begin
        logic [TI-1:0] held;
        logic          held_inv, held_inx;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 valid", longint'(out_valid), 0);
        chk("R1 int", longint'(out_int), 0);
        chk("R1 flags", longint'({out_invalid, out_inexact}), 0);
        rst_n = 1'b1;
        // R5..R9: sweep of all normalized mantissas
        for (int s = 0; s < 2; s++)
            for (int e = -10; e <= 12; e++)
                for (int m = 32; m < 64; m++)
                    run_vec(1, s, e, m);
        // R4: zero class ignores other fields
        for (int k = 0; k < 8; k++) run_vec(0, k & 1, k * 3 - 9, 32 + k * 4);
        // R10: infinity and NaN, both signs
        for (int c = 2; c < 4; c++)
            for (int s = 0; s < 2; s++) run_vec(c, s, 1, 40);
        // R8/R9 boundary at -128 and +128
        run_vec(1, 1, 7, 32);
        run_vec(1, 0, 7, 32);
        // R3: idle cycles hold the outputs
        run_vec(1, 0, 2, 45);
        held = out_int; held_inv = out_invalid; held_inx = out_inexact;
        @(negedge clk);
        in_class = 2'b11; in_sign = 1'b1; in_exp = 6'd20; in_mant = 6'd63;
        repeat (2) @(negedge clk);
        chk("R3 valid", longint'(out_valid), 0);
        chk("R3 int", longint'(out_int), longint'(held));
        chk("R3 flags", longint'({out_invalid, out_inexact}), longint'({held_inv, held_inx}));
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule